// File: doc/BRIEF.md
# Nine-Bit Command-Word Serializer

This block turns one register write for a display controller into a burst on a write-only serial link. Upstream logic offers a request through a valid/ready handshake. A request carries an 8-bit register address, a parameter count of zero, one or two bytes, and up to 16 bits of parameter data. The block then lowers chip select and shifts out the words. The first word is the command word, holding the address behind a clear flag bit. Each data word holds one byte behind a set flag bit. When the last bit has been shifted, the block raises chip select and pulses `tx_done`.

The link uses SPI mode 3. The clock rests high, a new bit is placed on the falling edge, and the receiver samples on the rising edge. Each half period of the serial clock lasts `HALF_DIV` system cycles. Between groups, chip select stays high for a full serial clock period before a new request is taken. A 16-bit parameter goes out high byte first.

Top module: `nine_bit_cmd_tx`

## Requirements
- R1: The first word of every group is the command word: 9 bits, bit 8 = 0, bits 7..0 = `req_addr`.
- R2: Every word that follows the command word has bit 8 = 1.
- R3: With `req_nbytes` = 2, the data words carry `req_data[15:8]` and then `req_data[7:0]`. With `req_nbytes` = 1, the single data word carries `req_data[7:0]`.
- R4: A group holds 9*(1+n) bits, where n is `req_nbytes`. The value 3 is treated as 2, and n = 0 sends the command word alone.
- R5: Within a word, bit 8 goes out first and bit 0 last.
- R6: `sclk` is high whenever `cs_n` is high. Inside a group, `mosi` changes only in the cycle where `sclk` falls, so it is stable at every rising edge.
- R7: `cs_n` falls one cycle after acceptance, with `sclk` high. It stays low for `HALF_DIV`*(1+2*bits) cycles: a lead half period, then a low half period and a high half period for each bit.
- R8: After a group, `cs_n` stays high for 2*`HALF_DIV` cycles before `req_ready` rises again.
- R9: `req_ready` is low from the cycle after acceptance until the gap of R8 ends. A request offered while `req_ready` is low is neither taken nor allowed to change the group in flight.
- R10: `tx_done` is a one-cycle pulse, once per group, in the first cycle in which `cs_n` is high again.
- R11: After reset, `cs_n` = 1, `sclk` = 1, `mosi` = 0, `req_ready` = 1 and `tx_done` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 8 | Register address for the command word |
| req_nbytes | input | 2 | Parameter byte count (3 acts as 2) |
| req_data | input | 16 | Parameter bytes; [15:8] is sent first when the count is 2 |
| tx_done | output | 1 | Pulse at the end of a group |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench rebuilds each bit stream from the rising edges of `sclk` and compares it with words it forms itself. This catches a design that swaps the byte order of a 16-bit parameter, drops the data flag bit, or sends LSB first. It sends counts of 0 and 3 to expose a bit counter that is off by one word or handles count 3 wrongly. It offers a competing request in the middle of a group, which shows whether the design latches data while busy or starts a second group. It also measures the chip-select low time, the guard gap and the `tx_done` position, so a design that clips the last high half period or returns `req_ready` too early shows up as a wrong cycle count.

// File: rtl/nine_bit_pkg.sv
package nine_bit_pkg;
  localparam int WORD_W    = 9;
  localparam int MAX_BYTES = 2;
  localparam int FRAME_W   = WORD_W * (1 + MAX_BYTES);
  localparam int BITS_W    = $clog2(FRAME_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_LOW, ST_HIGH, ST_GUARD
  } tx_state_t;

  function automatic logic [1:0] clamp_count(input logic [1:0] n);
    return (n > 2'd2) ? 2'd2 : n;
  endfunction

  function automatic logic [BITS_W-1:0] group_bits(input logic [1:0] n);
    return BITS_W'(WORD_W * (1 + int'(clamp_count(n))));
  endfunction

  // Left-aligned bit stream: command word, then data words.
  function automatic logic [FRAME_W-1:0] pack_group(input logic [7:0]  addr,
                                                    input logic [1:0]  n,
                                                    input logic [15:0] data);
    logic [FRAME_W-1:0] f;
    case (clamp_count(n))
      2'd0:    f = {1'b0, addr, 18'd0};
      2'd1:    f = {1'b0, addr, 1'b1, data[7:0], 9'd0};
      default: f = {1'b0, addr, 1'b1, data[15:8], 1'b1, data[7:0]};
    endcase
    return f;
  endfunction
endpackage

// File: rtl/nine_bit_phase_timer.sv
module nine_bit_phase_timer #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic long_phase,
  output logic expire
);
  localparam int CW = $clog2(2 * HALF_DIV + 1);
  localparam logic [CW-1:0] SHORT_LIM = CW'(HALF_DIV - 1);
  localparam logic [CW-1:0] LONG_LIM  = CW'(2 * HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim    = long_phase ? LONG_LIM : SHORT_LIM;
  assign expire = run && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (expire)   cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LONG_LIM);
  p_idle_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);
endmodule

// File: rtl/nine_bit_shifter.sv
module nine_bit_shifter #(
  parameter int W = 27
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         top_bit
);
  logic [W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr <= '0;
    else if (load)  sr <= load_val;
    else if (shift) sr <= {sr[W-2:0], 1'b0};
  end

  assign top_bit = sr[W-1];

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !shift |=> $stable(top_bit));
endmodule

// File: rtl/nine_bit_cmd_tx.sv
module nine_bit_cmd_tx
  import nine_bit_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [7:0]  req_addr,
  input  logic [1:0]  req_nbytes,
  input  logic [15:0] req_data,
  output logic        tx_done,
  output logic        sclk,
  output logic        mosi,
  output logic        cs_n
);
  tx_state_t         state;
  logic [BITS_W-1:0] bits_left;
  logic              accept, expire, last_bit, shift_now, sr_top;

  assign accept    = req_valid && req_ready;
  assign last_bit  = (bits_left == BITS_W'(1));
  assign shift_now = (state == ST_HIGH) && expire && !last_bit;

  nine_bit_phase_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .run(state != ST_IDLE), .long_phase(state == ST_GUARD),
    .expire(expire)
  );

  nine_bit_shifter #(.W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(accept), .load_val(pack_group(req_addr, req_nbytes, req_data)),
    .shift(shift_now), .top_bit(sr_top)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bits_left <= '0;
      tx_done   <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          state     <= ST_LEAD;
          bits_left <= group_bits(req_nbytes);
        end
        ST_LEAD: if (expire) state <= ST_LOW;
        ST_LOW:  if (expire) state <= ST_HIGH;
        ST_HIGH: if (expire) begin
          if (last_bit) begin
            state   <= ST_GUARD;
            tx_done <= 1'b1;
          end else begin
            state     <= ST_LOW;
            bits_left <= bits_left - 1'b1;
          end
        end
        ST_GUARD: if (expire) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign cs_n      = (state == ST_IDLE) || (state == ST_GUARD);
  assign sclk      = (state != ST_LOW);
  assign mosi      = cs_n ? 1'b0 : sr_top;

  p_sclk_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);
  p_mosi_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n && $past(!cs_n) && !$fell(sclk) |-> $stable(mosi));
  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !req_ready);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);
  p_done_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> $rose(cs_n));
  p_cs_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !cs_n && sclk);
  p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n && !req_ready);
endmodule

// File: tb/sim_nine_bit_cmd_tx.sv
module sim_nine_bit_cmd_tx;
  localparam int HALF = 2;
  localparam int NV = 6;
  // {addr, count, data}
  localparam logic [25:0] VEC [NV] = '{
    {8'h5A, 2'd0, 16'h0000},
    {8'hC3, 2'd1, 16'h00A5},
    {8'h81, 2'd2, 16'h3C96},
    {8'h07, 2'd2, 16'hFF00},
    {8'hE4, 2'd1, 16'h7E01},
    {8'h12, 2'd3, 16'hB44B}
  };

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, tx_done, sclk, mosi, cs_n;
  logic [7:0] req_addr = 0;
  logic [1:0] req_nbytes = 0;
  logic [15:0] req_data = 0;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  nine_bit_cmd_tx #(.HALF_DIV(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_nbytes(req_nbytes), .req_data(req_data),
    .tx_done(tx_done), .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] a, input logic [1:0] n, input logic [15:0] d,
                      input bit disturb);
    int nb, nbits, low_cyc, gap, rises, dones, mchg, rdy_hi, lead_bad;
    logic [8:0] words [3];
    logic [26:0] got;
    logic psclk, pmosi;
    nb = (n == 2'd3) ? 2 : int'(n);
    words[0] = {1'b0, a};
    for (int i = 0; i < nb; i++)
      words[i+1] = {1'b1, (nb == 2 && i == 0) ? d[15:8] : d[7:0]};
    nbits = 9 * (nb + 1);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_addr = a; req_nbytes = n; req_data = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    lead_bad = (!cs_n && sclk) ? 0 : 1;
    chk(lead_bad == 0, "R7 cs low with sclk high after accept", int'(cs_n), 0);
    low_cyc = 0; rises = 0; dones = 0; mchg = 0; rdy_hi = 0; got = '0;
    psclk = 1; pmosi = mosi;
    while (!cs_n && low_cyc < 1000) begin
      low_cyc++;
      if (req_ready) rdy_hi++;
      if (tx_done) dones++;
      if (sclk && !psclk) begin
        if (rises < 27) got[26 - rises] = mosi;
        rises++;
      end
      if (sclk && psclk && mosi !== pmosi) mchg++;
      if (disturb && low_cyc == 5) begin
        req_valid = 1; req_addr = ~a; req_nbytes = 2'd2; req_data = ~d;
      end
      if (disturb && low_cyc == 15) req_valid = 0;
      psclk = sclk; pmosi = mosi;
      @(negedge clk);
    end
    chk(tx_done == 1 && dones == 0, "R10 done at cs rise", int'(tx_done), 1);
    chk(rises == nbits, "R4 bit count", rises, nbits);
    chk(got[26:18] == words[0], "R1 command word", int'(got[26:18]), int'(words[0]));
    chk(got[25] == a[7], "R5 msb first", int'(got[25]), int'(a[7]));
    for (int i = 0; i < nb; i++) begin
      chk(got[17 - 9*i] == 1'b1, "R2 data flag", int'(got[17 - 9*i]), 1);
      chk(got[17 - 9*i -: 9] == words[i+1], "R3 data word order",
          int'(got[17 - 9*i -: 9]), int'(words[i+1]));
    end
    chk(mchg == 0, "R6 mosi stable while sclk high", mchg, 0);
    chk(low_cyc == HALF * (1 + 2 * nbits), "R7 cs low length", low_cyc,
        HALF * (1 + 2 * nbits));
    chk(rdy_hi == 0, "R9 ready low while busy", rdy_hi, 0);
    gap = 0;
    while (!req_ready && gap < 1000) begin
      if (!cs_n || !sclk) mchg++;
      if (gap > 0 && tx_done) dones++;
      gap++;
      @(negedge clk);
    end
    chk(gap == 2 * HALF, "R8 guard gap", gap, 2 * HALF);
    chk(dones == 0 && mchg == 0, "R10 single done pulse / R6 idle sclk", dones, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset values
    chk(cs_n == 1 && sclk == 1 && mosi == 0 && req_ready == 1 && tx_done == 0,
        "R11 reset state", {cs_n, sclk, mosi, req_ready, tx_done}, 5'b11010);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n == 1 && req_ready == 1, "R11 idle after reset", {cs_n, req_ready}, 2'b11);
    for (int v = 0; v < NV; v++)
      send(VEC[v][25:18], VEC[v][17:16], VEC[v][15:0], 1'b0);
    // R9: competing request during a group is ignored
    send(8'h3B, 2'd2, 16'h1234, 1'b1);
    begin
      int lows = 0;
      for (int k = 0; k < 20; k++) begin
        if (!cs_n) lows++;
        @(negedge clk);
      end
      chk(lows == 0, "R9 busy request not taken", lows, 0);
    end
    // back-to-back requests (R8 gap between groups)
    send(8'hA0, 2'd1, 16'h0055, 1'b0);
    send(8'hA1, 2'd0, 16'h0000, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule